// File: doc/BRIEF.md
# Prioritized Interrupt Control Unit

This block collects interrupt requests from a small set of peripheral and external lines and presents one interrupt line to the processor. Each source has its own control word. The word holds an enable, a request flag that software can see, a sense mode chosen from four options, and a three-bit priority level. A global threshold field decides which levels may interrupt at all.

Every source line passes through a two-flop synchronizer. Detection then works in one of two ways. In an edge mode a qualifying edge latches the request flag, and the flag stays set until software clears it. In a level mode the flag tracks the synchronized line. Among the sources that are enabled, pending and let through by the threshold, the arbiter picks one winner. The lowest level number wins, and a tie goes to the lower identifier. The winner's identifier is registered as the status value, and the processor interrupt is raised while that value is nonzero. Source identifiers are sparse and come from a parameter list.

Software reaches the block through a simple synchronous register port. The port has a word address, a write enable, write data and a combinational read-data output.

Top module: `icu_top`

## Requirements
- R1: After reset every source is disabled at level 7 in sense mode 00 with its flag clear, the threshold is 0, the status reads 0 and `irqOut` is low.
- R2: Register map, by word address. Address 0x00 is the status register (identifier in the low bits, read only). Address 0x01 holds the threshold in bits [18:16]. Address 0x10+i holds the control word of source index i: level in bits [2:0], sense mode in bits [5:4], request flag at bit 8 and enable at bit 12. All other bits read 0.
- R3: Sense mode 10 (rising edge) and mode 00 (falling edge) latch the flag when the synchronized line makes that transition. The flag stays set after the line returns. It clears only when software writes that source's control word with bit 8 equal to 0, and a detected edge in the same cycle takes precedence over the clear.
- R4: Sense mode 11 (high level) and mode 01 (low level) make the flag follow the synchronized line. Software writes to bit 8 then have no effect.
- R5: A change on a source line reaches `irqOut` on the fourth rising clock edge after it is applied: two synchronizer stages, then the flag, then the status register.
- R6: A source whose enable bit is 0 never wins. Its flag is still updated and can still be read.
- R7: A source at level 7 never wins, even when it is enabled and pending.
- R8: A source passes the threshold only when its level is less than the threshold value. A threshold of 0 blocks all sources.
- R9: Among qualifying sources, the lowest level number wins. A tie in level goes to the lower identifier, whatever the source's position in the list.
- R10: One clock after the arbitration result changes, the status register holds the winner's identifier, or 0 when nothing qualifies. `irqOut` is high exactly when the status is nonzero.
- R11: Identifiers come from the parameter list `SRC_ID`. The default list, by index 0..5, is 16, 1, 33, 48, 7, 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W (6) | Register word address |
| regWe | input | 1 | Write enable, sampled on the rising edge |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| srcIn | input | NUM_SRC (6) | Asynchronous source request lines |
| irqOut | output | 1 | Interrupt to the processor |

## Verification
The hardest situation to reach is a tie between sources at the same level where the winner sits later in the list. With the default list, index 5 carries identifier 21 and index 2 carries 33, so a tie between them must go to index 5. The bench builds this tie on purpose by reprogramming the levels while both lines are held active. A random phase then programs every source with a random level, enable and level-sense polarity, together with a random threshold and random input values, and compares the status against a priority model in the bench. Edge latching, the fact that flag writes do nothing in level modes, and the four-edge input latency are covered by directed sequences timed to the clock edge.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int DATA_W   = 32;
  localparam int LVL_W    = 3;
  localparam int LVL_LSB  = 0;
  localparam int MODE_LSB = 4;
  localparam int FLAG_BIT = 8;
  localparam int EN_BIT   = 12;
  localparam int MASK_LSB = 16;

  localparam logic [LVL_W-1:0] LVL_OFF = 3'd7;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  // write strobe bundle from control to datapath
  typedef struct packed {
    logic             maskWe;
    logic             wrEn;
    sense_e           wrMode;
    logic             wrFlag;
    logic [LVL_W-1:0] wrLevel;
    logic [LVL_W-1:0] wrMask;
  } wrStrobe_t;

  function automatic logic isLevelSense(input sense_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/icu_arbiter.sv
module icu_arbiter
  import icu_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ID_W    = 6,
  parameter int unsigned SRC_ID [NUM_SRC] = '{16, 1, 33, 48, 7, 21},
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]            eligVec,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] levelVec,
  output logic                          winValid,
  output logic [IDX_W-1:0]              winIdx,
  output logic [LVL_W-1:0]              winLevel,
  output logic [ID_W-1:0]               winId
);

  // linear scan: lower level first, lower identifier on ties
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winLevel = LVL_OFF;
    winId    = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligVec[i] &&
          (!winValid || (levelVec[i] < winLevel) ||
           ((levelVec[i] == winLevel) && (ID_W'(SRC_ID[i]) < winId)))) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winLevel = levelVec[i];
        winId    = ID_W'(SRC_ID[i]);
      end
    end
  end

endmodule

// File: rtl/icu_datapath.sv
module icu_datapath
  import icu_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ID_W    = 6,
  parameter int unsigned SRC_ID [NUM_SRC] = '{16, 1, 33, 48, 7, 21},
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStrobe_t                     strobe,
  input  logic [NUM_SRC-1:0]            ctrlWe,
  input  logic [NUM_SRC-1:0]            srcIn,
  output logic [NUM_SRC-1:0]            syncVec,
  output logic [NUM_SRC-1:0]            flagVec,
  output logic [NUM_SRC-1:0]            enVec,
  output logic [NUM_SRC-1:0][1:0]       modeVec,
  output logic [NUM_SRC-1:0][LVL_W-1:0] levelVec,
  output logic [LVL_W-1:0]              maskLevel,
  output logic                          winValid,
  output logic [IDX_W-1:0]              winIdx,
  output logic [LVL_W-1:0]              winLevel,
  output logic [ID_W-1:0]               statusId
);

  logic [NUM_SRC-1:0] eligVec;
  logic [ID_W-1:0]    winId;

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    logic             sMeta, sSync, sPrev;
    logic             flagQ, enQ;
    sense_e           modeQ;
    logic [LVL_W-1:0] lvlQ;
    sense_e           nextMode;
    logic             edgeHit;
    logic             levelHit;

    always_comb begin
      nextMode = ctrlWe[i] ? strobe.wrMode : modeQ;
      edgeHit  = ((nextMode == SENSE_RISE) &&  sSync && !sPrev) ||
                 ((nextMode == SENSE_FALL) && !sSync &&  sPrev);
      levelHit = (nextMode == SENSE_HIGH) ? sSync : !sSync;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sMeta <= 1'b0;
        sSync <= 1'b0;
        sPrev <= 1'b0;
        flagQ <= 1'b0;
        enQ   <= 1'b0;
        modeQ <= SENSE_FALL;
        lvlQ  <= LVL_OFF;
      end else begin
        sMeta <= srcIn[i];
        sSync <= sMeta;
        sPrev <= sSync;
        if (ctrlWe[i]) begin
          enQ   <= strobe.wrEn;
          modeQ <= strobe.wrMode;
          lvlQ  <= strobe.wrLevel;
        end
        if (isLevelSense(nextMode)) begin
          flagQ <= levelHit;
        end else if (edgeHit) begin
          flagQ <= 1'b1;
        end else if (ctrlWe[i] && !strobe.wrFlag) begin
          flagQ <= 1'b0;
        end
      end
    end

    assign syncVec[i]  = sSync;
    assign flagVec[i]  = flagQ;
    assign enVec[i]    = enQ;
    assign modeVec[i]  = modeQ;
    assign levelVec[i] = lvlQ;
    assign eligVec[i]  = flagQ && enQ && (lvlQ != LVL_OFF) && (lvlQ < maskLevel);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLevel <= '0;
    end else if (strobe.maskWe) begin
      maskLevel <= strobe.wrMask;
    end
  end

  icu_arbiter #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W),
    .SRC_ID  (SRC_ID)
  ) uArb (
    .eligVec  (eligVec),
    .levelVec (levelVec),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winLevel (winLevel),
    .winId    (winId)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusId <= '0;
    end else begin
      statusId <= winValid ? winId : '0;
    end
  end

endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_SRC   = 6,
  parameter int ID_W      = 6,
  parameter int ADDR_W    = 6,
  parameter int CTRL_BASE = 16,
  parameter int STAT_ADDR = 0,
  parameter int MASK_ADDR = 1
) (
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWe,
  input  logic [DATA_W-1:0]             regWdata,
  input  logic [NUM_SRC-1:0]            flagVec,
  input  logic [NUM_SRC-1:0]            enVec,
  input  logic [NUM_SRC-1:0][1:0]       modeVec,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] levelVec,
  input  logic [LVL_W-1:0]              maskLevel,
  input  logic [ID_W-1:0]               statusId,
  output wrStrobe_t                     strobe,
  output logic [NUM_SRC-1:0]            ctrlWe,
  output logic [DATA_W-1:0]             regRdata
);

  always_comb begin
    strobe.maskWe  = regWe && (regAddr == ADDR_W'(MASK_ADDR));
    strobe.wrEn    = regWdata[EN_BIT];
    strobe.wrMode  = sense_e'(regWdata[MODE_LSB +: 2]);
    strobe.wrFlag  = regWdata[FLAG_BIT];
    strobe.wrLevel = regWdata[LVL_LSB +: LVL_W];
    strobe.wrMask  = regWdata[MASK_LSB +: LVL_W];
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gDec
    assign ctrlWe[i] = regWe && (regAddr == ADDR_W'(CTRL_BASE + i));
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(STAT_ADDR)) begin
      regRdata[ID_W-1:0] = statusId;
    end else if (regAddr == ADDR_W'(MASK_ADDR)) begin
      regRdata[MASK_LSB +: LVL_W] = maskLevel;
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (regAddr == ADDR_W'(CTRL_BASE + i)) begin
        regRdata[LVL_LSB +: LVL_W] = levelVec[i];
        regRdata[MODE_LSB +: 2]    = modeVec[i];
        regRdata[FLAG_BIT]         = flagVec[i];
        regRdata[EN_BIT]           = enVec[i];
      end
    end
  end

endmodule

// File: rtl/icu_top.sv
module icu_top
  import icu_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int ID_W    = 6,
  parameter int ADDR_W  = 6,
  parameter int unsigned SRC_ID [NUM_SRC] = '{16, 1, 33, 48, 7, 21},
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  wrStrobe_t                     strobe;
  logic [NUM_SRC-1:0]            ctrlWe;
  logic [NUM_SRC-1:0]            syncVec;
  logic [NUM_SRC-1:0]            flagVec;
  logic [NUM_SRC-1:0]            enVec;
  logic [NUM_SRC-1:0][1:0]       modeVec;
  logic [NUM_SRC-1:0][LVL_W-1:0] levelVec;
  logic [LVL_W-1:0]              maskLevel;
  logic                          winValid;
  logic [IDX_W-1:0]              winIdx;
  logic [LVL_W-1:0]              winLevel;
  logic [ID_W-1:0]               statusId;

  icu_ctrl #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W),
    .ADDR_W  (ADDR_W)
  ) uCtrl (
    .regAddr   (regAddr),
    .regWe     (regWe),
    .regWdata  (regWdata),
    .flagVec   (flagVec),
    .enVec     (enVec),
    .modeVec   (modeVec),
    .levelVec  (levelVec),
    .maskLevel (maskLevel),
    .statusId  (statusId),
    .strobe    (strobe),
    .ctrlWe    (ctrlWe),
    .regRdata  (regRdata)
  );

  icu_datapath #(
    .NUM_SRC (NUM_SRC),
    .ID_W    (ID_W),
    .SRC_ID  (SRC_ID)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .ctrlWe    (ctrlWe),
    .srcIn     (srcIn),
    .syncVec   (syncVec),
    .flagVec   (flagVec),
    .enVec     (enVec),
    .modeVec   (modeVec),
    .levelVec  (levelVec),
    .maskLevel (maskLevel),
    .winValid  (winValid),
    .winIdx    (winIdx),
    .winLevel  (winLevel),
    .statusId  (statusId)
  );

  assign irqOut = (statusId != '0);

endmodule

// File: rtl/icu_checker.sv
module icu_checker
  import icu_pkg::*;
#(
  parameter int NUM_SRC = 6,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [NUM_SRC-1:0]            ctrlWe,
  input logic [NUM_SRC-1:0]            syncVec,
  input logic [NUM_SRC-1:0]            flagVec,
  input logic [NUM_SRC-1:0]            enVec,
  input logic [NUM_SRC-1:0][1:0]       modeVec,
  input logic [NUM_SRC-1:0][LVL_W-1:0] levelVec,
  input logic [LVL_W-1:0]              maskLevel,
  input logic                          winValid,
  input logic [IDX_W-1:0]              winIdx,
  input logic [LVL_W-1:0]              winLevel,
  input logic                          irqOut
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqOut);

  p_winner_enabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (enVec[winIdx] && flagVec[winIdx]));

  p_winner_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (winLevel != LVL_OFF) && (winLevel < maskLevel));

  p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskLevel == '0) |=> !irqOut);

  p_raise_r10: assert property (@(posedge clk) disable iff (!rstN)
    winValid |=> irqOut);

  p_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    !winValid |=> !irqOut);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrcChk
    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (flagVec[i] && !modeVec[i][0] && !ctrlWe[i]) |=> flagVec[i]);

    p_level_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
      (modeVec[i][0] && !ctrlWe[i]) |=>
        (flagVec[i] == ($past(syncVec[i]) == $past(modeVec[i][1]))));

    p_priority_r9: assert property (@(posedge clk) disable iff (!rstN)
      (flagVec[i] && enVec[i] && (levelVec[i] < maskLevel)) |->
        (winValid && (winLevel <= levelVec[i])));
  end

endmodule

bind icu_top icu_checker #(.NUM_SRC(NUM_SRC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlWe    (ctrlWe),
  .syncVec   (syncVec),
  .flagVec   (flagVec),
  .enVec     (enVec),
  .modeVec   (modeVec),
  .levelVec  (levelVec),
  .maskLevel (maskLevel),
  .winValid  (winValid),
  .winIdx    (winIdx),
  .winLevel  (winLevel),
  .irqOut    (irqOut)
);

// File: tb/tb_icu_top.sv
`timescale 1ns/1ps
module tb_icu_top;

  localparam int NSRC = 6;
  localparam int AW   = 6;
  localparam int CTRL = 16;
  localparam int unsigned IDS [NSRC] = '{16, 1, 33, 48, 7, 21};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic          regWe = 1'b0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NSRC-1:0] srcIn = '0;
  logic          irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state for the random phase
  bit       mEn  [NSRC];
  bit       mHigh[NSRC];
  int       mLvl [NSRC];
  int       mMask;

  always #4 clk = ~clk;

  icu_top dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .srcIn(srcIn), .irqOut(irqOut)
  );

  function automatic logic [31:0] ctrlWord(input bit en, input int mode,
                                           input bit flag, input int lvl);
    logic [31:0] w;
    w = '0;
    w[12]  = en;
    w[8]   = flag;
    w[5:4] = mode[1:0];
    w[2:0] = lvl[2:0];
    return w;
  endfunction

  function automatic int expWinner();
    int best;
    int bestLvl;
    best = 0;
    bestLvl = 8;
    for (int i = 0; i < NSRC; i++) begin
      bit pend;
      pend = mHigh[i] ? srcIn[i] : !srcIn[i];
      if (mEn[i] && pend && mLvl[i] != 7 && mLvl[i] < mMask) begin
        if (mLvl[i] < bestLvl || (mLvl[i] == bestLvl && int'(IDS[i]) < best)) begin
          best = int'(IDS[i]);
          bestLvl = mLvl[i];
        end
      end
    end
    return best;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regAddr  = AW'(a);
    regWdata = d;
    regWe    = 1'b1;
    @(negedge clk);
    regWe    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = AW'(a);
    #1;
    d = regRdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle(2);

    // R1 reset state, R2 layout of reset values
    rd(0, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irqOut}, 32'h0);
    rd(1, d); chk("R1 threshold after reset", d, 32'h0);
    for (int i = 0; i < NSRC; i++) begin
      rd(CTRL + i, d); chk("R1 control word after reset", d, 32'h7);
    end

    // R2 threshold field position
    wr(1, 32'h0007_0000);
    rd(1, d); chk("R2 threshold readback", d, 32'h0007_0000);

    // R3 rising edge on index 1 (id 1)
    wr(CTRL + 1, ctrlWord(1, 2, 0, 3));
    @(negedge clk) srcIn[1] = 1'b1;
    settle(2);
    srcIn[1] = 1'b0;
    settle(6);
    rd(0, d); chk("R3 rising edge latched, status id 1 (R11)", d, 32'd1);
    rd(CTRL + 1, d); chk("R3 flag held after line returns", d, 32'h0000_1123);
    wr(CTRL + 1, ctrlWord(1, 2, 0, 3));
    settle(2);
    rd(CTRL + 1, d); chk("R3 flag cleared by writing 0", d, 32'h0000_1023);
    rd(0, d); chk("R3 status back to 0", d, 32'h0);

    // R3 falling edge on index 4 (id 7)
    wr(CTRL + 4, ctrlWord(1, 0, 0, 2));
    @(negedge clk) srcIn[4] = 1'b1;
    settle(6);
    chk("R3 no request on rising line in falling mode", {31'b0, irqOut}, 32'h0);
    srcIn[4] = 1'b0;
    settle(6);
    rd(0, d); chk("R3 falling edge latched, status id 7", d, 32'd7);
    wr(CTRL + 4, ctrlWord(1, 0, 0, 2));
    settle(2);
    chk("R3 irq drops after clear", {31'b0, irqOut}, 32'h0);

    // R5 latency through high-level sense on index 0 (id 16)
    wr(CTRL + 0, ctrlWord(1, 3, 0, 4));
    settle(3);
    @(negedge clk) srcIn[0] = 1'b1;
    settle(3);
    chk("R5 irq still low after three edges", {31'b0, irqOut}, 32'h0);
    settle(1);
    chk("R5 irq high on fourth edge", {31'b0, irqOut}, 32'h1);
    rd(0, d); chk("R10 status id 16", d, 32'd16);

    // R4 flag write ignored in level mode
    wr(CTRL + 0, ctrlWord(1, 3, 0, 4));
    settle(3);
    rd(CTRL + 0, d); chk("R4 flag write ignored in level mode", d, 32'h0000_1134);
    srcIn[0] = 1'b0;
    settle(6);
    rd(CTRL + 0, d); chk("R4 flag follows line low", d, 32'h0000_1034);
    chk("R10 irq low with nothing pending", {31'b0, irqOut}, 32'h0);

    // R6 disabled but pending source on index 2 (id 33)
    wr(CTRL + 2, ctrlWord(0, 3, 0, 1));
    srcIn[2] = 1'b1;
    settle(6);
    rd(CTRL + 2, d); chk("R6 flag visible while disabled", d, 32'h0000_0131);
    rd(0, d); chk("R6 disabled source does not interrupt", d, 32'h0);

    // R7 level 7 never interrupts
    wr(CTRL + 2, ctrlWord(1, 3, 0, 7));
    settle(3);
    rd(0, d); chk("R7 level 7 blocked", d, 32'h0);

    // R8 threshold
    wr(CTRL + 2, ctrlWord(1, 3, 0, 3));
    wr(1, 32'h0003_0000);
    settle(2);
    rd(0, d); chk("R8 level 3 blocked by threshold 3", d, 32'h0);
    wr(1, 32'h0004_0000);
    settle(2);
    rd(0, d); chk("R8 level 3 passes threshold 4", d, 32'd33);
    wr(1, 32'h0000_0000);
    settle(2);
    chk("R8 threshold 0 blocks all", {31'b0, irqOut}, 32'h0);

    // R9 priority and identifier tie-break
    wr(1, 32'h0007_0000);
    wr(CTRL + 5, ctrlWord(1, 3, 0, 1));
    srcIn[5] = 1'b1;
    settle(6);
    rd(0, d); chk("R9 lower level wins (id 21 over 33)", d, 32'd21);
    wr(CTRL + 5, ctrlWord(1, 3, 0, 3));
    wr(CTRL + 3, ctrlWord(1, 3, 0, 3));
    srcIn[3] = 1'b1;
    settle(6);
    rd(0, d); chk("R9 tie goes to lower id 21 despite later index", d, 32'd21);
    wr(CTRL + 0, ctrlWord(1, 3, 0, 3));
    srcIn[0] = 1'b1;
    settle(6);
    rd(0, d); chk("R9 tie goes to id 16", d, 32'd16);
    wr(CTRL + 3, ctrlWord(1, 3, 0, 0));
    settle(3);
    rd(0, d); chk("R9 level 0 wins (id 48)", d, 32'd48);

    // random phase: level modes, random levels, enables and threshold
    for (int it = 0; it < 40; it++) begin
      srcIn = NSRC'($urandom);
      for (int i = 0; i < NSRC; i++) begin
        mEn[i]   = 1'($urandom);
        mHigh[i] = 1'($urandom);
        mLvl[i]  = int'($urandom % 8);
        wr(CTRL + i, ctrlWord(mEn[i], mHigh[i] ? 3 : 1, 0, mLvl[i]));
      end
      mMask = int'($urandom % 8);
      wr(1, 32'(mMask) << 16);
      settle(5);
      rd(0, d); chk("R9 random status vs model", d, 32'(expWinner()));
      chk("R10 random irq vs model", {31'b0, irqOut}, {31'b0, expWinner() != 0});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule